// File: doc/BRIEF.md
# Flash Transfer Chunking Engine

This block accepts one long flash request made of a start address, a byte length and an operation: read, write or erase. It turns that request into a series of cycles that a hardware flash sequencer accepts. For read and write, each cycle is bounded by the sequencer's 64-byte data buffer and may not cross a 256-byte page. For erase, each cycle covers one erase block.

For every cycle the engine places the address, the byte count minus one and a cycle code on the sequencer side, and raises a one-cycle start strobe. It then reads the sequencer status at a fixed interval until it sees a done or error flag, or until its poll budget runs out. After each poll sequence it writes the status back to clear the flags. The stale flags are also cleared before a transfer starts.

Read bytes leave the engine one per cycle after each chunk. Write bytes are pulled from the source into the sequencer buffer before the chunk starts. The request ends with one `done` pulse, and `ok` tells success from failure.

Top module: `flash_chunker`

## Requirements
- R1: Each read or write chunk is the smaller of the remaining length and BUF_BYTES (64).
- R2: A read or write chunk never crosses a PAGE_BYTES (256) boundary. A chunk starting at address A holds at most 256 minus A[7:0] bytes.
- R3: Before the first cycle of a read or write, `seq_clr` pulses once. Before every erase block it also pulses once.
- R4: `seq_go` is a one-cycle strobe. In that cycle `seq_addr` holds the chunk address and `seq_count` holds the byte count minus one. For erase, `seq_count` is 0. `seq_cycle` is 2'b00 for read, 2'b10 for write and 2'b11 for erase.
- R5: An erase is rejected with no cycle issued when its address or length is not a multiple of ERASE_BYTES (4096). Otherwise it issues one cycle per block, and each block's address is ERASE_BYTES above the previous one.
- R6: A request whose address plus length exceeds FLASH_BYTES is rejected with no cycle issued. A request that ends exactly at FLASH_BYTES is accepted.
- R7: The `req_op` codes are 0 for read, 1 for write and 2 for erase. Code 3 is rejected. A zero-length request that is in range completes with `ok` set and no cycle.
- R8: `seq_poll` samples status first in the cycle after `seq_go`, and then every POLL_GAP (4) cycles. The budget is RW_POLLS (16) polls for read and write, and ERASE_POLLS (64) for erase. A done flag seen on the last allowed poll counts as success.
- R9: Every poll sequence, whether it succeeds, errs or times out, is followed by exactly one `seq_clr` pulse.
- R10: An error flag, or an exhausted budget, aborts the request with `ok` low and no further cycles. An error flag wins over a done flag seen in the same poll.
- R11: After each read chunk completes, its bytes appear on `rd_byte` with `rd_valid`, one per cycle, in address order.
- R12: For a write, the engine pulls the chunk's bytes from `wr_data` with `wr_take`, one per cycle. It stores them in buffer slots 0 upward before `seq_go`.
- R13: `req_valid` is ignored while `busy` is high. `done` is a one-cycle pulse, and `ok` is high only together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_op | input | 2 | 0 read, 1 write, 2 erase |
| req_addr | input | AW | Start byte address |
| req_len | input | AW | Length in bytes |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| ok | output | 1 | Request succeeded (valid with done) |
| seq_clr | output | 1 | Write-one-to-clear of sequencer status flags |
| seq_go | output | 1 | Cycle start strobe |
| seq_poll | output | 1 | Status sample strobe |
| seq_addr | output | AW | Chunk address |
| seq_count | output | log2(BUF_BYTES) | Byte count minus one |
| seq_cycle | output | 2 | Cycle code |
| seq_done | input | 1 | Sequencer done flag |
| seq_err | input | 1 | Sequencer error flag |
| buf_idx | output | log2(BUF_BYTES) | Sequencer buffer slot |
| buf_we | output | 1 | Buffer write enable |
| buf_wdata | output | 8 | Buffer write byte |
| buf_rdata | input | 8 | Buffer read byte at buf_idx |
| wr_data | input | 8 | Next write source byte |
| wr_take | output | 1 | Write source byte consumed |
| rd_valid | output | 1 | Read byte valid |
| rd_byte | output | 8 | Read byte |

## Verification
On one poll the sequencer's done flag can meet the last unit of the poll budget, and it can also meet the error flag. The modelled sequencer raises done exactly on poll RW_POLLS, which must end in success. It then raises done one poll later, which must end in a timeout failure. It also raises done and error on the same poll, and the expected result is a failed request. Each case is judged by `ok` at the `done` pulse and by the number of polls and status clears.

// File: rtl/flash_chunker.sv
module flash_chunker #(
  parameter int AW          = 24,
  parameter int FLASH_BYTES = 1 << 20,
  parameter int BUF_BYTES   = 64,
  parameter int PAGE_BYTES  = 256,
  parameter int ERASE_BYTES = 4096,
  parameter int POLL_GAP    = 4,
  parameter int RW_POLLS    = 16,
  parameter int ERASE_POLLS = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic [1:0]                    req_op,
  input  logic [AW-1:0]                 req_addr,
  input  logic [AW-1:0]                 req_len,
  output logic                          busy,
  output logic                          done,
  output logic                          ok,
  output logic                          seq_clr,
  output logic                          seq_go,
  output logic                          seq_poll,
  output logic [AW-1:0]                 seq_addr,
  output logic [$clog2(BUF_BYTES)-1:0]  seq_count,
  output logic [1:0]                    seq_cycle,
  input  logic                          seq_done,
  input  logic                          seq_err,
  output logic [$clog2(BUF_BYTES)-1:0]  buf_idx,
  output logic                          buf_we,
  output logic [7:0]                    buf_wdata,
  input  logic [7:0]                    buf_rdata,
  input  logic [7:0]                    wr_data,
  output logic                          wr_take,
  output logic                          rd_valid,
  output logic [7:0]                    rd_byte
);
  localparam int CW   = $clog2(BUF_BYTES);
  localparam int PB   = $clog2(PAGE_BYTES);
  localparam int EB   = $clog2(ERASE_BYTES);
  localparam int GW   = $clog2(POLL_GAP + 1);
  localparam int MAXP = (RW_POLLS > ERASE_POLLS) ? RW_POLLS : ERASE_POLLS;
  localparam int TW   = $clog2(MAXP + 1);
  localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_ER = 2'd2;

  typedef enum logic [3:0] {
    S_IDLE, S_CLR, S_FILL, S_GO, S_WAIT, S_ACK, S_DRAIN, S_NEXT, S_FIN
  } st_t;

  st_t            st;
  logic [1:0]     op;
  logic [AW-1:0]  addr, left;
  logic [CW-1:0]  idx;
  logic [GW-1:0]  gap;
  logic [TW-1:0]  budget;
  logic           bad;

  logic [AW-1:0]  room, lim, chunk;
  logic [CW-1:0]  last;
  logic [AW:0]    req_end;
  logic           misalign, reject;

  assign room  = AW'(PAGE_BYTES) - AW'(addr[PB-1:0]);
  assign lim   = (left < AW'(BUF_BYTES)) ? left : AW'(BUF_BYTES);
  assign chunk = (op == OP_ER) ? AW'(ERASE_BYTES) : ((lim < room) ? lim : room);
  assign last  = CW'(chunk - AW'(1));

  assign req_end  = {1'b0, req_addr} + {1'b0, req_len};
  assign misalign = (req_addr[EB-1:0] != '0) || (req_len[EB-1:0] != '0);
  assign reject   = (req_end > (AW+1)'(FLASH_BYTES)) || (req_op == 2'd3) ||
                    ((req_op == OP_ER) && misalign);

  assign busy      = (st != S_IDLE);
  assign done      = (st == S_FIN);
  assign ok        = done && !bad;
  assign seq_clr   = (st == S_CLR) || (st == S_ACK);
  assign seq_go    = (st == S_GO);
  assign seq_poll  = (st == S_WAIT) && (gap == '0);
  assign seq_addr  = addr;
  assign seq_count = (op == OP_ER) ? '0 : last;
  assign seq_cycle = (op == OP_RD) ? 2'b00 : (op == OP_WR) ? 2'b10 : 2'b11;
  assign buf_idx   = idx;
  assign buf_we    = (st == S_FILL);
  assign buf_wdata = wr_data;
  assign wr_take   = buf_we;
  assign rd_valid  = (st == S_DRAIN);
  assign rd_byte   = buf_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      op     <= OP_RD;
      addr   <= '0;
      left   <= '0;
      idx    <= '0;
      gap    <= '0;
      budget <= '0;
      bad    <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          op   <= req_op;
          addr <= req_addr;
          left <= req_len;
          bad  <= reject;
          st   <= (reject || req_len == '0) ? S_FIN : S_CLR;
        end
        S_CLR: begin
          idx <= '0;
          st  <= (op == OP_WR) ? S_FILL : S_GO;
        end
        S_FILL: begin
          idx <= idx + CW'(1);
          if (idx == last) st <= S_GO;
        end
        S_GO: begin
          gap    <= '0;
          budget <= (op == OP_ER) ? TW'(ERASE_POLLS) : TW'(RW_POLLS);
          st     <= S_WAIT;
        end
        S_WAIT:
          if (gap != '0) gap <= gap - GW'(1);
          else if (seq_err) begin
            bad <= 1'b1;
            st  <= S_ACK;
          end else if (seq_done) st <= S_ACK;
          else if (budget == TW'(1)) begin
            bad <= 1'b1;
            st  <= S_ACK;
          end else begin
            budget <= budget - TW'(1);
            gap    <= GW'(POLL_GAP - 1);
          end
        S_ACK: begin
          idx <= '0;
          st  <= bad ? S_FIN : ((op == OP_RD) ? S_DRAIN : S_NEXT);
        end
        S_DRAIN: begin
          idx <= idx + CW'(1);
          if (idx == last) st <= S_NEXT;
        end
        S_NEXT: begin
          addr <= addr + chunk;
          left <= left - chunk;
          idx  <= '0;
          if (left == chunk) st <= S_FIN;
          else if (op == OP_ER) st <= S_CLR;
          else if (op == OP_WR) st <= S_FILL;
          else st <= S_GO;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_chunker_chk.sv
module flash_chunker_chk #(
  parameter int AW          = 24,
  parameter int BUF_BYTES   = 64,
  parameter int PAGE_BYTES  = 256,
  parameter int ERASE_BYTES = 4096,
  parameter int POLL_GAP    = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          req_valid,
  input logic                          busy,
  input logic                          done,
  input logic                          ok,
  input logic                          seq_go,
  input logic                          seq_poll,
  input logic [AW-1:0]                 seq_addr,
  input logic [$clog2(BUF_BYTES)-1:0]  seq_count,
  input logic [1:0]                    seq_cycle,
  input logic                          rd_valid
);
  localparam int PB = $clog2(PAGE_BYTES);
  localparam int EB = $clog2(ERASE_BYTES);
  localparam int SW = (PB > $clog2(BUF_BYTES) ? PB : $clog2(BUF_BYTES)) + 1;

  assert_page_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_go && seq_cycle != 2'b11) |->
      (SW'(seq_addr[PB-1:0]) + SW'(seq_count)) < SW'(PAGE_BYTES));

  assert_block_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_go && seq_cycle == 2'b11) |-> (seq_addr[EB-1:0] == '0));

  assert_go_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    seq_go |=> !seq_go);

  assert_ok_with_done_R13: assert property (@(posedge clk) disable iff (!rst_n)
    ok |-> done);

  assert_done_single_R13: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_accept_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> busy);

  assert_read_in_txn_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> busy);

  generate
    if (POLL_GAP > 1) begin : g_gap
      assert_poll_spaced_R8: assert property (@(posedge clk) disable iff (!rst_n)
        seq_poll |=> !seq_poll);
    end
  endgenerate
endmodule

bind flash_chunker flash_chunker_chk #(
  .AW(AW), .BUF_BYTES(BUF_BYTES), .PAGE_BYTES(PAGE_BYTES),
  .ERASE_BYTES(ERASE_BYTES), .POLL_GAP(POLL_GAP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy), .done(done),
  .ok(ok), .seq_go(seq_go), .seq_poll(seq_poll), .seq_addr(seq_addr),
  .seq_count(seq_count), .seq_cycle(seq_cycle), .rd_valid(rd_valid)
);

// File: tb/flash_chunker_test.sv
`timescale 1ns/1ps
module flash_chunker_test;
  localparam int AW = 24;
  localparam int CW = 6;
  localparam int RW_POLLS = 16;

  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic req_valid = 0;
  logic [1:0] req_op = 0;
  logic [AW-1:0] req_addr = 0, req_len = 0;
  logic busy, done, ok, seq_clr, seq_go, seq_poll, seq_done, seq_err;
  logic [AW-1:0] seq_addr;
  logic [CW-1:0] seq_count, buf_idx;
  logic [1:0] seq_cycle;
  logic buf_we, wr_take, rd_valid;
  logic [7:0] buf_wdata, buf_rdata, wr_data, rd_byte;

  flash_chunker uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_len(req_len), .busy(busy), .done(done), .ok(ok),
    .seq_clr(seq_clr), .seq_go(seq_go), .seq_poll(seq_poll), .seq_addr(seq_addr),
    .seq_count(seq_count), .seq_cycle(seq_cycle), .seq_done(seq_done),
    .seq_err(seq_err), .buf_idx(buf_idx), .buf_we(buf_we), .buf_wdata(buf_wdata),
    .buf_rdata(buf_rdata), .wr_data(wr_data), .wr_take(wr_take),
    .rd_valid(rd_valid), .rd_byte(rd_byte));

  function automatic logic [7:0] fmem(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction
  function automatic logic [7:0] src(input int k);
    return 8'(k * 7 + 1);
  endfunction

  // sequencer model
  logic [7:0] sbuf [0:63];
  logic [AW-1:0] g_addr [0:63];
  logic [CW-1:0] g_cnt [0:63];
  logic [1:0] g_cyc [0:63];
  logic [7:0] g_b0 [0:63];
  logic [7:0] rlog [0:1023];
  logic [7:0] wlog [0:1023];
  int n_go = 0, n_clr = 0, n_poll = 0, n_rd = 0, n_wr = 0;
  int polls_seen = 0, cyc = 0, first_poll = 0, last_poll = 0;
  logic armed = 0;
  int resp_at = 3, err_go = -1;
  logic resp_done = 1;

  assign buf_rdata = sbuf[buf_idx];
  assign wr_data   = src(n_wr);
  assign seq_done  = armed && resp_done && (polls_seen + 1 >= resp_at);
  assign seq_err   = armed && (n_go == err_go) && (polls_seen + 1 >= resp_at);

  initial for (int i = 0; i < 64; i++) sbuf[i] = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (buf_we) begin
      sbuf[buf_idx] <= buf_wdata;
      wlog[n_wr] <= buf_wdata;
      n_wr <= n_wr + 1;
    end
    if (seq_go) begin
      g_addr[n_go] <= seq_addr; g_cnt[n_go] <= seq_count;
      g_cyc[n_go] <= seq_cycle; g_b0[n_go] <= sbuf[0];
      n_go <= n_go + 1; polls_seen <= 0; armed <= 1;
      if (seq_cycle == 2'b00)
        for (int i = 0; i < 64; i++) sbuf[i] <= fmem(seq_addr + AW'(i));
    end
    if (seq_poll) begin
      if (polls_seen == 0) first_poll <= cyc;
      last_poll <= cyc;
      polls_seen <= polls_seen + 1;
      n_poll <= n_poll + 1;
    end
    if (seq_clr) begin n_clr <= n_clr + 1; armed <= 0; end
    if (rd_valid) begin rlog[n_rd] <= rd_byte; n_rd <= n_rd + 1; end
  end

  int checks = 0, fails = 0;
  task automatic chk(input bit c, input string req, input longint act, input longint exp);
    checks++;
    if (!c) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  int s_go, s_clr, s_poll, s_rd, s_wr;
  logic got_ok;
  task automatic run(input logic [1:0] op, input logic [AW-1:0] a, input logic [AW-1:0] l);
    s_go = n_go; s_clr = n_clr; s_poll = n_poll; s_rd = n_rd; s_wr = n_wr;
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = a; req_len = l;
    @(negedge clk);
    req_valid = 0;
    for (int i = 0; i < 20000; i++) begin
      if (done) break;
      @(negedge clk);
    end
    got_ok = ok;
    chk(done, "R13 done seen", done, 1);
    @(negedge clk);
    chk(!done, "R13 done single", done, 0);
  endtask

  task automatic t_reset;
    chk(!busy && !done && !seq_go && !seq_clr && !seq_poll, "R13 reset idle",
        {busy, done, seq_go, seq_clr, seq_poll}, 0);
  endtask

  task automatic t_read_long;
    int bad = 0;
    run(0, 24'h000000, 100);
    chk(got_ok, "R1 read ok", got_ok, 1);
    chk(n_go - s_go == 2, "R1 chunk count", n_go - s_go, 2);
    chk(g_cnt[s_go] == 63 && g_cnt[s_go+1] == 35, "R1 counts",
        {g_cnt[s_go], g_cnt[s_go+1]}, {6'd63, 6'd35});
    chk(g_addr[s_go+1] == 24'h40, "R4 second addr", g_addr[s_go+1], 24'h40);
    chk(g_cyc[s_go] == 2'b00, "R4 read code", g_cyc[s_go], 0);
    chk(n_clr - s_clr == 3, "R3 R9 clears", n_clr - s_clr, 3);
    chk(n_rd - s_rd == 100, "R11 byte count", n_rd - s_rd, 100);
    for (int k = 0; k < 100; k++) if (rlog[s_rd+k] != fmem(AW'(k))) bad++;
    chk(bad == 0, "R11 read data order", bad, 0);
  endtask

  task automatic t_read_page;
    int bad = 0;
    run(0, 24'h0000F0, 40);
    chk(got_ok && n_go - s_go == 2, "R2 page chunks", n_go - s_go, 2);
    chk(g_cnt[s_go] == 15 && g_addr[s_go+1] == 24'h100 && g_cnt[s_go+1] == 23,
        "R2 cut at page", {g_cnt[s_go], g_cnt[s_go+1]}, {6'd15, 6'd23});
    for (int k = 0; k < 40; k++) if (rlog[s_rd+k] != fmem(24'hF0 + AW'(k))) bad++;
    chk(bad == 0, "R11 page read data", bad, 0);
  endtask

  task automatic t_write;
    int bad = 0;
    run(1, 24'h0001FC, 70);
    chk(got_ok, "R12 write ok", got_ok, 1);
    chk(n_go - s_go == 3, "R1 R2 write chunks", n_go - s_go, 3);
    chk(g_cnt[s_go] == 3 && g_cnt[s_go+1] == 63 && g_cnt[s_go+2] == 1,
        "R2 write counts", {g_cnt[s_go], g_cnt[s_go+1], g_cnt[s_go+2]},
        {6'd3, 6'd63, 6'd1});
    chk(g_addr[s_go+1] == 24'h200 && g_addr[s_go+2] == 24'h240, "R4 write addrs",
        g_addr[s_go+2], 24'h240);
    chk(g_cyc[s_go] == 2'b10, "R4 write code", g_cyc[s_go], 2);
    chk(n_wr - s_wr == 70, "R12 bytes taken", n_wr - s_wr, 70);
    for (int k = 0; k < 70; k++) if (wlog[s_wr+k] != src(s_wr + k)) bad++;
    chk(bad == 0, "R12 write data", bad, 0);
    chk(g_b0[s_go+1] == src(s_wr+4) && g_b0[s_go+2] == src(s_wr+68),
        "R12 slot0 per chunk", g_b0[s_go+2], src(s_wr+68));
    chk(n_clr - s_clr == 4, "R3 R9 write clears", n_clr - s_clr, 4);
  endtask

  task automatic t_erase;
    run(2, 24'h002000, 24'h2000);
    chk(got_ok && n_go - s_go == 2, "R5 erase blocks", n_go - s_go, 2);
    chk(g_addr[s_go] == 24'h2000 && g_addr[s_go+1] == 24'h3000, "R5 erase advance",
        g_addr[s_go+1], 24'h3000);
    chk(g_cyc[s_go] == 2'b11 && g_cnt[s_go] == 0, "R4 erase code",
        {g_cyc[s_go], g_cnt[s_go]}, {2'b11, 6'd0});
    chk(n_clr - s_clr == 4, "R3 clear per block", n_clr - s_clr, 4);
    run(2, 24'h002100, 24'h1000);
    chk(!got_ok && n_go == s_go && n_clr == s_clr, "R5 misaligned addr",
        n_go - s_go, 0);
    run(2, 24'h002000, 24'h0800);
    chk(!got_ok && n_go == s_go, "R5 misaligned len", n_go - s_go, 0);
  endtask

  task automatic t_range;
    run(0, 24'h0FFFF0, 24'h20);
    chk(!got_ok && n_go == s_go, "R6 past end", n_go - s_go, 0);
    run(0, 24'h0FFFC0, 24'h40);
    chk(got_ok && n_go - s_go == 1, "R6 ends at size", n_go - s_go, 1);
    run(0, 24'h000100, 0);
    chk(got_ok && n_go == s_go && n_clr == s_clr, "R7 zero length", n_go - s_go, 0);
    run(3, 24'h000100, 8);
    chk(!got_ok && n_go == s_go, "R7 op 3 rejected", n_go - s_go, 0);
  endtask

  task automatic t_poll;
    resp_done = 0;
    run(0, 24'h000300, 8);
    chk(!got_ok, "R10 timeout fails", got_ok, 0);
    chk(n_poll - s_poll == RW_POLLS, "R8 rw budget", n_poll - s_poll, RW_POLLS);
    chk(last_poll - first_poll == (RW_POLLS - 1) * 4, "R8 poll interval",
        last_poll - first_poll, (RW_POLLS - 1) * 4);
    chk(n_clr - s_clr == 2 && n_rd == s_rd, "R9 clear after timeout",
        n_clr - s_clr, 2);
    resp_done = 1; resp_at = RW_POLLS;
    run(0, 24'h000300, 8);
    chk(got_ok && n_poll - s_poll == RW_POLLS, "R8 done on last poll", got_ok, 1);
    resp_at = RW_POLLS + 1;
    run(0, 24'h000300, 8);
    chk(!got_ok, "R8 done one poll late", got_ok, 0);
    resp_at = 40;
    run(2, 24'h000000, 24'h1000);
    chk(got_ok && n_poll - s_poll == 40, "R8 erase budget longer",
        n_poll - s_poll, 40);
    resp_at = 3;
  endtask

  task automatic t_error;
    err_go = n_go + 2;
    run(0, 24'h000000, 100);
    chk(!got_ok && n_go - s_go == 2, "R10 abort on chunk 2", n_go - s_go, 2);
    chk(n_rd - s_rd == 64, "R10 no drain after error", n_rd - s_rd, 64);
    err_go = n_go + 1;
    run(0, 24'h000500, 8);
    chk(!got_ok && n_rd == s_rd, "R10 error beats done", got_ok, 0);
    err_go = -1;
  endtask

  task automatic t_busy;
    s_go = n_go;
    @(negedge clk);
    req_valid = 1; req_op = 0; req_addr = 24'h000600; req_len = 8;
    @(negedge clk);
    req_op = 2; req_addr = 24'h004000; req_len = 24'h1000;
    chk(busy, "R13 busy", busy, 1);
    @(negedge clk);
    req_valid = 0;
    for (int i = 0; i < 2000; i++) begin
      if (done) break;
      @(negedge clk);
    end
    chk(ok && n_go - s_go == 1 && g_cyc[s_go] == 2'b00, "R13 request ignored while busy",
        n_go - s_go, 1);
    @(negedge clk);
    chk(!busy, "R13 idle after", busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_read_long;
    t_read_page;
    t_write;
    t_erase;
    t_range;
    t_poll;
    t_error;
    t_busy;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule